// File: doc/BRIEF.md
# Bit-Clock Source Selector

This block settles, once per link reset, where the 12.288 MHz serial bit clock of an audio codec comes from. While the link reset input is asserted it watches the sensed level of the bidirectional bit-clock pin. It samples that level on a free-running sampling clock. If it counts enough transitions within a sampling window, another agent on the link owns the clock. The block then latches consumer mode and never enables its pin driver.

If no activity was seen, the block waits for the link reset to be released and then consults three presence flags for local references. A 24.576 MHz crystal wins over a 24.576 MHz oscillator, which wins over a 14.318 MHz oscillator. With a 24.576 MHz reference the block produces the bit clock itself by halving the reference. With the 14.318 MHz oscillator it only raises a select toward an external synthesiser, which generates the bit clock. With no reference at all it reports an error.

The decision is held until the link reset is asserted again. That clears the decision and starts a fresh detection. Analog presence sensing and the synthesiser are outside the block.

Top module: `clksrc_sel_top`

## Requirements
- R1: While the block reset `rst_ni` is low, `src_o` is 0 and `bclk_oe_o`, `err_o`, `pll_sel_o` and `bclk_div_o` are all 0.
- R2: `src_o` uses these codes: 0 undecided, 1 outside clock (consumer), 2 crystal, 3 24.576 MHz oscillator, 4 14.318 MHz oscillator, 7 no source (error).
- R3: If, while `link_rst_ni` is low, the pin shows at least MIN_EDGES level changes within one window of WIN_LEN sampling cycles, `src_o` becomes 1 before the link reset is released. `bclk_oe_o` stays 0 throughout.
- R4: Fewer than MIN_EDGES level changes within a window, such as a single glitch pulse or three changes, leave `src_o` at 0.
- R5: Without detected activity, `src_o` stays 0 while the link reset is low. After release it picks 2 if `xtal_ok_i` is set, else 3 if `osc24_ok_i` is set, else 4 if `osc14_ok_i` is set.
- R6: Without detected activity and with no presence flag set, `src_o` becomes 7 after release and `err_o` is 1. `err_o` is 0 for every other code.
- R7: `bclk_oe_o` is 1 only for codes 2, 3 and 4.
- R8: Once decided, `src_o` ignores later changes of the presence flags and later pin activity until the link reset is asserted again.
- R9: Asserting `link_rst_ni` again returns `src_o` to 0 and restarts activity detection.
- R10: `bclk_div_o` is 0 unless the code is 2 or 3. In those cases, after crossing into the reference domain, it starts low and inverts on every rising edge of `ref_clk_i`.
- R11: `pll_sel_o` is 1 only for code 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running sampling clock |
| rst_ni | input | 1 | Block reset, asynchronous assert, active low |
| link_rst_ni | input | 1 | Link reset being observed, active low, asynchronous to clk_i |
| ref_clk_i | input | 1 | 24.576 MHz local reference used for halving |
| bclk_pin_i | input | 1 | Sensed level of the bit-clock pin |
| xtal_ok_i | input | 1 | 24.576 MHz crystal present |
| osc24_ok_i | input | 1 | 24.576 MHz oscillator present |
| osc14_ok_i | input | 1 | 14.318 MHz oscillator present |
| src_o | output | 3 | Latched source code |
| bclk_oe_o | output | 1 | Enable for the bit-clock pin driver |
| bclk_div_o | output | 1 | Reference halved to 12.288 MHz |
| pll_sel_o | output | 1 | Select for the external synthesiser |
| err_o | output | 1 | No clock source found |

## Verification
The embedded properties hold on every cycle for the following behaviours:
- A decided code stays put while the link reset is high.
- A new link reset returns the code to undecided.
- No local code appears while the link reset stays low.
- A detector pulse during reset yields consumer mode.
- The detector fires only when enabled.
- The grant is one-hot.
- The halved clock inverts on every enabled reference edge.

Other behaviours only the bench scenarios can show:
- The full priority outcome over all flag patterns, with and without pin activity.
- Rejection of short bursts of transitions.
- That later flag changes and pin toggling leave a latched code alone.
- The expected levels of the enable, error and select outputs.

// File: rtl/clksrc_pkg.sv
package clksrc_pkg;

  typedef enum logic [2:0] {
    SRC_UNDEC = 3'd0,
    SRC_EXT   = 3'd1,
    SRC_XTAL  = 3'd2,
    SRC_OSC24 = 3'd3,
    SRC_OSC14 = 3'd4,
    SRC_ERR   = 3'd7
  } src_e;

  localparam int unsigned NUM_LOCAL = 3;

endpackage

// File: rtl/clksrc_sync.sv
module clksrc_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] ff_q;
  logic [STAGES-1:0] ff_d;

  always_comb begin
    ff_d = {ff_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ff_q <= {STAGES{RST_VAL}};
    end else begin
      ff_q <= ff_d;
    end
  end

  assign q_o = ff_q[STAGES-1];

endmodule

// File: rtl/clksrc_act_det.sv
module clksrc_act_det #(
  parameter int unsigned WIN_LEN     = 16,
  parameter int unsigned MIN_EDGES   = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic pin_i,
  output logic act_o
);

  localparam int unsigned WW = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam int unsigned EW = $clog2(MIN_EDGES + 1);
  localparam logic [WW-1:0] WIN_LAST = WW'(WIN_LEN - 1);
  localparam logic [EW-1:0] EDGE_MAX = EW'(MIN_EDGES);

  logic          pin_s;
  logic          prev_q;
  logic          lvl_chg;
  logic [WW-1:0] win_q, win_d;
  logic [EW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d;

  clksrc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) pin_sync_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  assign lvl_chg = pin_s ^ prev_q;

  always_comb begin
    win_d = win_q;
    cnt_d = cnt_q;
    act_d = 1'b0;
    if (!en_i) begin
      win_d = '0;
      cnt_d = '0;
    end else begin
      if (lvl_chg && (cnt_q != EDGE_MAX)) begin
        cnt_d = cnt_q + EW'(1);
      end
      act_d = (cnt_d == EDGE_MAX);
      if (win_q == WIN_LAST) begin
        win_d = '0;
        cnt_d = '0;
      end else begin
        win_d = win_q + WW'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      win_q  <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
    end else begin
      prev_q <= pin_s;
      win_q  <= win_d;
      cnt_q  <= cnt_d;
      act_q  <= act_d;
    end
  end

  assign act_o = act_q;

  // R3
  act_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q |-> $past(en_i))
    else $error("detector pulse without enable");

  // R4
  idle_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0))
    else $error("edge count kept while disabled");

endmodule

// File: rtl/clksrc_prio.sv
module clksrc_prio
  import clksrc_pkg::*;
(
  input  logic [NUM_LOCAL-1:0] present_i,
  output src_e                 code_o
);

  logic [NUM_LOCAL-1:0] grant;

  always_comb begin
    logic seen;
    seen = 1'b0;
    for (int i = 0; i < NUM_LOCAL; i++) begin
      grant[i] = present_i[i] && !seen;
      seen     = seen | present_i[i];
    end
  end

  always_comb begin
    if (grant[0]) begin
      code_o = SRC_XTAL;
    end else if (grant[1]) begin
      code_o = SRC_OSC24;
    end else if (grant[2]) begin
      code_o = SRC_OSC14;
    end else begin
      code_o = SRC_ERR;
    end
  end

  // R5
  always_comb begin
    if (!$isunknown(present_i)) begin
      grant_onehot_chk: assert ($onehot0(grant))
        else $error("more than one local source granted");
    end
  end

endmodule

// File: rtl/clksrc_div2.sv
module clksrc_div2 #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic ref_clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic div_o
);

  logic en_s;
  logic div_q, div_d;

  clksrc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) en_sync_i (
    .clk_i (ref_clk_i),
    .rst_ni(rst_ni),
    .d_i   (en_i),
    .q_o   (en_s)
  );

  always_comb begin
    div_d = 1'b0;
    if (en_s) begin
      div_d = !div_q;
    end
  end

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= 1'b0;
    end else begin
      div_q <= div_d;
    end
  end

  assign div_o = div_q;

  // R10
  div_toggle_chk: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (en_s && $past(en_s)) |-> (div_q != $past(div_q)))
    else $error("halved clock missed a toggle");

  // R10
  div_quiet_chk: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    !en_s |=> !div_q)
    else $error("halved clock active while disabled");

endmodule

// File: rtl/clksrc_sel_top.sv
module clksrc_sel_top
  import clksrc_pkg::*;
#(
  parameter int unsigned WIN_LEN     = 16,
  parameter int unsigned MIN_EDGES   = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       link_rst_ni,
  input  logic       ref_clk_i,
  input  logic       bclk_pin_i,
  input  logic       xtal_ok_i,
  input  logic       osc24_ok_i,
  input  logic       osc14_ok_i,
  output logic [2:0] src_o,
  output logic       bclk_oe_o,
  output logic       bclk_div_o,
  output logic       pll_sel_o,
  output logic       err_o
);

  logic lrst_s;
  logic lrst_prev_q;
  logic lrst_fell;
  logic det_en;
  logic act_w;
  src_e pick_w;
  src_e src_q, src_d;
  logic div_en;

  clksrc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) lrst_sync_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (link_rst_ni),
    .q_o   (lrst_s)
  );

  assign lrst_fell = lrst_prev_q && !lrst_s;
  assign det_en    = !lrst_s && (src_q == SRC_UNDEC);

  clksrc_act_det #(
    .WIN_LEN    (WIN_LEN),
    .MIN_EDGES  (MIN_EDGES),
    .SYNC_STAGES(SYNC_STAGES)
  ) det_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (det_en),
    .pin_i (bclk_pin_i),
    .act_o (act_w)
  );

  clksrc_prio prio_i (
    .present_i({osc14_ok_i, osc24_ok_i, xtal_ok_i}),
    .code_o   (pick_w)
  );

  always_comb begin
    src_d = src_q;
    if (lrst_fell) begin
      src_d = SRC_UNDEC;
    end else if (!lrst_s) begin
      if ((src_q == SRC_UNDEC) && act_w) begin
        src_d = SRC_EXT;
      end
    end else if (src_q == SRC_UNDEC) begin
      src_d = pick_w;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q       <= SRC_UNDEC;
      lrst_prev_q <= 1'b0;
    end else begin
      src_q       <= src_d;
      lrst_prev_q <= lrst_s;
    end
  end

  assign div_en = (src_q == SRC_XTAL) || (src_q == SRC_OSC24);

  clksrc_div2 #(.SYNC_STAGES(SYNC_STAGES)) div_i (
    .ref_clk_i(ref_clk_i),
    .rst_ni   (rst_ni),
    .en_i     (div_en),
    .div_o    (bclk_div_o)
  );

  assign src_o     = src_q;
  assign bclk_oe_o = (src_q == SRC_XTAL) || (src_q == SRC_OSC24) || (src_q == SRC_OSC14);
  assign pll_sel_o = (src_q == SRC_OSC14);
  assign err_o     = (src_q == SRC_ERR);

  // R8
  src_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lrst_s && (src_q != SRC_UNDEC)) |=> (src_q == $past(src_q)))
    else $error("latched source changed");

  // R9
  relink_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lrst_fell |=> (src_q == SRC_UNDEC))
    else $error("link reset did not clear source");

  // R5
  no_early_pick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lrst_s && !$past(lrst_s)) |-> ((src_q == SRC_UNDEC) || (src_q == SRC_EXT)))
    else $error("local source chosen during link reset");

  // R3
  act_to_ext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_w && !lrst_s) |=> (src_q == SRC_EXT))
    else $error("activity did not select consumer mode");

endmodule

// File: tb/clksrc_sel_top_tb_top.sv
`timescale 1ns/1ps
module clksrc_sel_top_tb_top;

  logic       clk = 1'b0;
  logic       ref_clk = 1'b0;
  logic       rst_n;
  logic       link_rst_n;
  logic       pin;
  logic [2:0] flags;
  logic [2:0] src;
  logic       oe, div, pll, err;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;
  always #3.5 ref_clk = ~ref_clk;

  clksrc_sel_top #(.WIN_LEN(16), .MIN_EDGES(4), .SYNC_STAGES(2)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .link_rst_ni(link_rst_n),
    .ref_clk_i  (ref_clk),
    .bclk_pin_i (pin),
    .xtal_ok_i  (flags[0]),
    .osc24_ok_i (flags[1]),
    .osc14_ok_i (flags[2]),
    .src_o      (src),
    .bclk_oe_o  (oe),
    .bclk_div_o (div),
    .pll_sel_o  (pll),
    .err_o      (err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_code(input bit active, input logic [2:0] f);
    if (active)     return 1;
    if (f[0])       return 2;
    if (f[1])       return 3;
    if (f[2])       return 4;
    return 7;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic toggle_pin(input int n);
    for (int i = 0; i < n; i++) begin
      pin = ~pin;
      cyc(2);
    end
  endtask

  task automatic run_case(input logic [2:0] f, input bit active);
    int e;
    logic [2:0] held;
    logic prev;
    e = exp_code(active, f);
    link_rst_n = 1'b0;
    pin = 1'b0;
    flags = f;
    cyc(5);
    chk(src == 3'd0, "R9 cleared on link reset", src, 0);
    if (active) toggle_pin(20);
    else cyc(40);
    cyc(6);
    chk(src == (active ? 3'd1 : 3'd0), active ? "R3 consumer during reset" : "R5 undecided during reset",
        src, active ? 1 : 0);
    chk(oe == 1'b0, "R3 no drive during reset", oe, 0);
    link_rst_n = 1'b1;
    cyc(8);
    chk(src == 3'(e), "R2 R5 source code", src, e);
    chk(oe == (e == 2 || e == 3 || e == 4), "R7 output enable", oe, (e == 2 || e == 3 || e == 4));
    chk(err == (e == 7), "R6 error flag", err, (e == 7));
    chk(pll == (e == 4), "R11 synth select", pll, (e == 4));
    held = src;
    flags = ~f;
    toggle_pin(20);
    cyc(4);
    chk(src == held, "R8 latched after decision", src, held);
    pin = 1'b0;
    repeat (8) @(posedge ref_clk);
    #1 prev = div;
    for (int i = 0; i < 8; i++) begin
      @(posedge ref_clk);
      #1;
      if (e == 2 || e == 3) chk(div == !prev, "R10 halved clock toggles", div, !prev);
      else chk(div == 1'b0, "R10 halved clock idle", div, 0);
      prev = div;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    link_rst_n = 1'b0;
    pin = 1'b0;
    flags = 3'b111;
    cyc(6);
    // R1 reset state
    chk(src == 3'd0, "R1 src in reset", src, 0);
    chk(oe == 1'b0, "R1 oe in reset", oe, 0);
    chk(err == 1'b0, "R1 err in reset", err, 0);
    chk(pll == 1'b0, "R1 pll in reset", pll, 0);
    chk(div == 1'b0, "R1 div in reset", div, 0);
    rst_n = 1'b1;
    cyc(4);

    // R4 glitch and short bursts rejected
    pin = 1'b1; cyc(1); pin = 1'b0;
    cyc(40);
    chk(src == 3'd0, "R4 single glitch ignored", src, 0);
    pin = 1'b1; cyc(2); pin = 1'b0; cyc(2); pin = 1'b1;
    cyc(40);
    chk(src == 3'd0, "R4 three changes ignored", src, 0);
    pin = 1'b0;
    flags = 3'b000;
    link_rst_n = 1'b1;
    cyc(8);
    chk(src == 3'd7, "R6 no source after short bursts", src, 7);

    // full sweep: all presence patterns, with and without outside clock
    for (int a = 0; a < 2; a++) begin
      for (int f = 0; f < 8; f++) begin
        run_case(3'(f), a[0]);
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule